// File: doc/BRIEF.md
# Serial Frame Reader for Ready/Data Converters

This block is the host side of a two-wire link to one or more delta-sigma converters. Each converter has a single output that goes low to signal a finished conversion and then carries the result bits. The block drives one serial clock shared by all converters. It samples up to `NUM_LANES` of those combined ready/data lines in parallel, and it turns one command into a complete clock waveform.

Five commands differ in two ways: how many clocks the frame has, and whether the serial clock rests low or high afterwards. A plain read uses 24 clocks. A read with release adds a 25th clock so that the converter's line returns high and can be polled. A read with calibration adds a 26th clock and then waits for the next ready indication. Standby parks the clock high. A single-shot conversion wakes the converters by dropping the clock, reads one result and parks the clock high again.

With several converters, the frame starts only when every ready line is low. If the lines do not all go low, it starts once a skew allowance, counted from the first low line, has run out. A ready timeout ends any wait that sees no low line at all. Results are sign-extended to 32 bits. A one-cycle `done` strobe ends each command, and `busy` covers the command from acceptance to completion.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after it is released, `sclk`, `busy`, `done` and `err` are low and every lane of `words` is zero.
- R2: A command is accepted only when `cmd_valid` is high while `busy` is low. The legal values of `cmd_op` are 0 read, 1 read with release, 2 read with calibration, 3 standby and 4 single shot. Codes 5 to 7 are ignored: no `busy`, no `done`, no clock edge. A command presented while `busy` is high is dropped.
- R3: After a command that reads is accepted, no rising edge appears on `sclk` until every lane of `rd_line` is low (lane i is bit i), unless R4 applies.
- R4: Once at least one lane is low, the frame starts after `skew_limit` system clocks even if other lanes are still high. A lane that stays high then reads as all ones.
- R5: Every high phase and every low phase of `sclk` within a frame lasts exactly `HALF_CLKS` system clocks, and no phase of `sclk` is ever shorter than that.
- R6: A read (op 0) gives 24 rising edges. Each lane's bit is sampled at the end of every high phase and assembled MSB first. The result is sign-extended from bit 23 into `words[32*i+31:32*i]`, and `words` changes only while `busy` is high.
- R7: A read with release (op 1) gives exactly 25 rising edges; the data is taken from the first 24.
- R8: A read with calibration (op 2) gives exactly 26 rising edges. It then keeps `busy` high and withholds `done` until the ready lines indicate ready again under the rules of R3 and R4.
- R9: Standby (op 3) drives `sclk` high and completes with `done`, and `sclk` stays high while idle. A later command other than standby first drops `sclk` for one half period before waiting for ready.
- R10: A single shot (op 4) issued from standby drops `sclk`, waits for ready, clocks 24 data edges and returns `sclk` high. That is 25 rising edges in all, and the block is left parked.
- R11: If no lane is low for `ready_limit` system clocks during a wait, the command ends with `done` and `err` high together. No clock edge is issued and `words` is left unchanged.
- R12: `done` is a single-cycle pulse that coincides with the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken while idle |
| cmd_op | input | 3 | Command code (0 read, 1 release, 2 calibrate, 3 standby, 4 single shot) |
| skew_limit | input | CNT_W | Allowance in system clocks after the first ready lane before clocking starts |
| ready_limit | input | CNT_W | System clocks with no ready lane before the wait is abandoned |
| rd_line | input | NUM_LANES | Combined ready/data lines, one per converter |
| sclk | output | 1 | Shared serial clock |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Ready timeout, valid with `done` |
| words | output | NUM_LANES*OUT_W | Sign-extended results, lane 0 in the low word |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the converter. These are the minimum width of each clock phase, the frozen clock and results while idle, the single-cycle done strobe at the end of `busy`, an error only together with done, and a cap of 26 rising edges per command. Only the bench's scenarios can show the rest, because each one depends on a converter model. The bench checks the assembled and sign-extended data values and the exact 24, 25 and 26 edge counts per command. It checks that clocking is held off until the last lane is ready, or until the skew allowance runs out. It also checks the wait for ready after calibration, the parked level after standby and single shot, and the timeout path.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      OP_READ    = 3'd0,
      OP_RELEASE = 3'd1,
      OP_CALIB   = 3'd2,
      OP_STANDBY = 3'd3,
      OP_SINGLE  = 3'd4
   } rd_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAKE,
      S_WAIT,
      S_HIGH,
      S_LOW,
      S_CALWAIT,
      S_FINISH
   } rd_state_e;

   function automatic logic op_legal(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

endpackage

// File: rtl/adc_rd_phase.sv
// Half-period timer for the serial clock: counts while running, pulses at the last cycle of a phase.
module adc_rd_phase #(
   parameter int HALF_CLKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int PW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [PW-1:0] LAST = PW'(HALF_CLKS - 1);

   logic [PW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + PW'(1);
   end
endmodule

// File: rtl/adc_rd_gate.sv
// Decides when a wait for ready ends: all lanes low, skew allowance spent, or timeout.
module adc_rd_gate #(
   parameter int NUM_LANES = 2,
   parameter int CNT_W     = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [NUM_LANES-1:0] lines,
   input  logic [CNT_W-1:0]     skew_limit,
   input  logic [CNT_W-1:0]     ready_limit,
   output logic                 go,
   output logic                 expired
);
   logic             any_low, all_low;
   logic [CNT_W-1:0] skew_cnt, tout_cnt;

   assign any_low = ~&lines;
   assign all_low = ~|lines;

   assign go      = en && (all_low || (any_low && (skew_cnt >= skew_limit)));
   assign expired = en && !any_low && (tout_cnt >= ready_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skew_cnt <= '0;
         tout_cnt <= '0;
      end else if (!en) begin
         skew_cnt <= '0;
         tout_cnt <= '0;
      end else if (any_low) begin
         if (skew_cnt != '1) skew_cnt <= skew_cnt + CNT_W'(1);
      end else begin
         if (tout_cnt != '1) tout_cnt <= tout_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/adc_rd_lane.sv
// One converter lane: input synchronizer, MSB-first shift register, sign-extended result register.
module adc_rd_lane #(
   parameter int WORD_W      = 24,
   parameter int OUT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_in,
   input  logic             shift_en,
   input  logic             capture,
   output logic             line_sync,
   output logic [OUT_W-1:0] word_out
);
   logic [SYNC_STAGES-1:0] sq;
   logic [WORD_W-1:0]      shreg;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= line_in;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= {sq[SYNC_STAGES-2:0], line_in};
         end
      end
   endgenerate

   assign line_sync = sq[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg <= '0;
      else if (shift_en) shreg <= {shreg[WORD_W-2:0], line_sync};
   end

   generate
      if (OUT_W > WORD_W) begin : g_ext
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       word_out <= '0;
            else if (capture) word_out <= {{(OUT_W-WORD_W){shreg[WORD_W-1]}}, shreg};
         end
      end else begin : g_flat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       word_out <= '0;
            else if (capture) word_out <= shreg;
         end
      end
   endgenerate
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adc_rd_pkg::*;
#(
   parameter int NUM_LANES    = 2,
   parameter int WORD_W       = 24,
   parameter int OUT_W        = 32,
   parameter int HALF_CLKS    = 10,
   parameter int SYS_CLK_MHZ  = 100,
   parameter int MIN_PULSE_NS = 100,
   parameter int SYNC_STAGES  = 2,
   parameter int CNT_W        = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [2:0]                 cmd_op,
   input  logic [CNT_W-1:0]           skew_limit,
   input  logic [CNT_W-1:0]           ready_limit,
   input  logic [NUM_LANES-1:0]       rd_line,
   output logic                       sclk,
   output logic                       busy,
   output logic                       done,
   output logic                       err,
   output logic [NUM_LANES*OUT_W-1:0] words
);
   localparam int EW = $clog2(WORD_W + 3);
   localparam logic [EW-1:0] LEN_WORD = EW'(WORD_W);
   localparam logic [EW-1:0] LEN_REL  = EW'(WORD_W + 1);
   localparam logic [EW-1:0] LEN_CAL  = EW'(WORD_W + 2);

   generate
      if (HALF_CLKS * 1000 < MIN_PULSE_NS * SYS_CLK_MHZ) begin : g_bad_half
         $error("HALF_CLKS gives an SCLK phase shorter than MIN_PULSE_NS");
      end
      if (HALF_CLKS <= SYNC_STAGES + 1) begin : g_bad_sync
         $error("HALF_CLKS must exceed SYNC_STAGES + 1 so data settles before sampling");
      end
      if (OUT_W < WORD_W || WORD_W < 2) begin : g_bad_width
         $error("OUT_W must be at least WORD_W and WORD_W at least 2");
      end
      if (NUM_LANES < 1 || SYNC_STAGES < 1) begin : g_bad_count
         $error("NUM_LANES and SYNC_STAGES must be at least 1");
      end
   endgenerate

   rd_state_e            state;
   rd_op_e               op_q;
   logic                 sclk_q, parked, done_q, err_q, err_pend;
   logic [EW-1:0]        edge_cnt, frame_end;
   logic                 tick, run, go, expired, gate_en;
   logic                 shift_en, capture, last_edge;
   logic [NUM_LANES-1:0] line_sync;

   assign run       = (state == S_WAKE) || (state == S_HIGH) || (state == S_LOW);
   assign gate_en   = (state == S_WAIT) || (state == S_CALWAIT);
   assign last_edge = (edge_cnt == frame_end);
   assign shift_en  = (state == S_HIGH) && tick && (edge_cnt <= LEN_WORD);
   assign capture   = (state == S_LOW) && tick && last_edge;

   always_comb begin
      case (op_q)
         OP_RELEASE: frame_end = LEN_REL;
         OP_CALIB:   frame_end = LEN_CAL;
         default:    frame_end = LEN_WORD;
      endcase
   end

   adc_rd_phase #(.HALF_CLKS(HALF_CLKS)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   adc_rd_gate #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .en(gate_en), .lines(line_sync),
      .skew_limit(skew_limit), .ready_limit(ready_limit),
      .go(go), .expired(expired)
   );

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         adc_rd_lane #(.WORD_W(WORD_W), .OUT_W(OUT_W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk(clk), .rst_n(rst_n), .line_in(rd_line[l]),
            .shift_en(shift_en), .capture(capture),
            .line_sync(line_sync[l]), .word_out(words[l*OUT_W +: OUT_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= OP_READ;
         sclk_q   <= 1'b0;
         parked   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         err_pend <= 1'b0;
         edge_cnt <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (cmd_valid && op_legal(cmd_op)) begin
                  op_q     <= rd_op_e'(cmd_op);
                  err_pend <= 1'b0;
                  if (cmd_op == 3'(OP_STANDBY)) begin
                     sclk_q <= 1'b1;
                     parked <= 1'b1;
                     state  <= S_FINISH;
                  end else if (parked) begin
                     sclk_q <= 1'b0;
                     parked <= 1'b0;
                     state  <= S_WAKE;
                  end else begin
                     state  <= S_WAIT;
                  end
               end
            end
            S_WAKE: if (tick) state <= S_WAIT;
            S_WAIT: begin
               if (expired) begin
                  err_pend <= 1'b1;
                  state    <= S_FINISH;
               end else if (go) begin
                  sclk_q   <= 1'b1;
                  edge_cnt <= EW'(1);
                  state    <= S_HIGH;
               end
            end
            S_HIGH: begin
               if (tick) begin
                  sclk_q <= 1'b0;
                  state  <= S_LOW;
               end
            end
            S_LOW: begin
               if (tick) begin
                  if (last_edge) begin
                     if (op_q == OP_CALIB) begin
                        state <= S_CALWAIT;
                     end else if (op_q == OP_SINGLE) begin
                        sclk_q <= 1'b1;
                        parked <= 1'b1;
                        state  <= S_FINISH;
                     end else begin
                        state  <= S_FINISH;
                     end
                  end else begin
                     sclk_q   <= 1'b1;
                     edge_cnt <= edge_cnt + EW'(1);
                     state    <= S_HIGH;
                  end
               end
            end
            S_CALWAIT: begin
               if (expired) begin
                  err_pend <= 1'b1;
                  state    <= S_FINISH;
               end else if (go) begin
                  state    <= S_FINISH;
               end
            end
            S_FINISH: begin
               done_q <= 1'b1;
               err_q  <= err_pend;
               state  <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign sclk = sclk_q;
   assign busy = (state != S_IDLE);
   assign done = done_q;
   assign err  = err_q;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
   parameter int NUM_LANES = 2,
   parameter int WORD_W    = 24,
   parameter int OUT_W     = 32,
   parameter int HALF_CLKS = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       sclk,
   input logic                       busy,
   input logic                       done,
   input logic                       err,
   input logic [NUM_LANES*OUT_W-1:0] words
);
   localparam int HW = $clog2(HALF_CLKS + 2);
   localparam int RW = $clog2(WORD_W + 4) + 1;
   localparam logic [HW-1:0] HALF_V = HW'(HALF_CLKS);
   localparam logic [RW-1:0] MAX_RISE = RW'(WORD_W + 2);

   logic          sclk_d;
   logic [HW-1:0] hold_cnt;
   logic [RW-1:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         hold_cnt <= HALF_V;
         rise_cnt <= '0;
      end else begin
         sclk_d <= sclk;
         if (sclk != sclk_d)      hold_cnt <= HW'(1);
         else if (hold_cnt < HALF_V) hold_cnt <= hold_cnt + HW'(1);
         if (!busy)               rise_cnt <= '0;
         else if (sclk && !sclk_d) rise_cnt <= rise_cnt + RW'(1);
      end
   end

   AST_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != sclk_d) |-> (hold_cnt >= HALF_V)); // R5
   AST_IDLE_SCLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> $stable(sclk)); // R9
   AST_IDLE_WORDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> $stable(words)); // R6
   AST_RISE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rise_cnt <= MAX_RISE); // R8
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R12
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R11
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
   .NUM_LANES(NUM_LANES), .WORD_W(WORD_W), .OUT_W(OUT_W), .HALF_CLKS(HALF_CLKS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy),
   .done(done), .err(err), .words(words)
);

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 2;
   localparam int WW    = 24;
   localparam int OW    = 32;
   localparam int HALF  = 10;
   localparam int CW    = 20;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cmd_valid = 1'b0;
   logic [2:0]          cmd_op = 3'd0;
   logic [CW-1:0]       skew_limit;
   logic [CW-1:0]       ready_limit;
   logic [LANES-1:0]    rd_line = '1;
   logic                sclk, busy, done, err;
   logic [LANES*OW-1:0] words;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_frame_reader #(
      .NUM_LANES(LANES), .WORD_W(WW), .OUT_W(OW), .HALF_CLKS(HALF), .CNT_W(CW)
   ) u_adc_frame_reader (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .skew_limit(skew_limit), .ready_limit(ready_limit), .rd_line(rd_line),
      .sclk(sclk), .busy(busy), .done(done), .err(err), .words(words)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // converter model: line low when ready, then one bit per rising edge, high from edge 25 on
   logic          sclk_q = 1'b0;
   int            m_total = 0;
   int            hi_run = 0;
   int            last_hi = 0;
   logic          m_armed [LANES];
   logic [WW-1:0] m_word  [LANES];
   int            m_base  [LANES];

   always @(negedge clk) begin
      if (sclk && !sclk_q) m_total = m_total + 1;
      if (sclk) hi_run = hi_run + 1;
      else if (sclk_q) begin
         last_hi = hi_run;
         hi_run  = 0;
      end
      sclk_q = sclk;
      for (int l = 0; l < LANES; l++) begin
         int k;
         k = m_total - m_base[l];
         if (!m_armed[l])   rd_line[l] = 1'b1;
         else if (k == 0)   rd_line[l] = 1'b0;
         else if (k <= WW)  rd_line[l] = m_word[l][WW-k];
         else               rd_line[l] = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] sext(input logic [WW-1:0] w);
      return {32'h0, {(OW-WW){w[WW-1]}}, w};
   endfunction

   function automatic logic [63:0] lane(input int l);
      return {32'h0, words[l*OW +: OW]};
   endfunction

   task automatic disarm();
      for (int l = 0; l < LANES; l++) m_armed[l] = 1'b0;
   endtask

   task automatic arm(input int l, input logic [WW-1:0] w);
      m_word[l]  = w;
      m_base[l]  = m_total;
      m_armed[l] = 1'b1;
   endtask

   task automatic issue(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(output bit got, output logic e, output logic b, output logic d2);
      got = 1'b0; e = 1'b0; b = 1'b1; d2 = 1'b1;
      for (int i = 0; i < 20000 && !got; i++) begin
         @(negedge clk);
         if (done) begin
            got = 1'b1;
            e   = err;
            b   = busy;
         end
      end
      @(negedge clk);
      d2 = done;
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk(!sclk && !busy && !done && !err, "R1 outputs in reset", {sclk, busy, done, err}, 0);
      chk(words == '0, "R1 words in reset", words, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!sclk && !busy && !done && !err && words == '0, "R1 after release",
          {sclk, busy, done, err}, 0);
   endtask

   task automatic test_read();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd0);
      repeat (5) @(negedge clk);
      arm(0, 24'h5A3C81); arm(1, 24'hA50F7E);
      wait_done(got, e, b, d2);
      chk(got && !e, "R6 read completes", {got, e}, 2);
      chk(lane(0) == sext(24'h5A3C81), "R6 lane0 positive", lane(0), sext(24'h5A3C81));
      chk(lane(1) == sext(24'hA50F7E), "R6 lane1 sign extended", lane(1), sext(24'hA50F7E));
      chk(m_total - st == 24, "R6 edge count", m_total - st, 24);
      chk(last_hi == HALF, "R5 high phase length", last_hi, HALF);
      chk(!b && !d2, "R12 done pulse with busy low", {b, d2}, 0);
   endtask

   task automatic test_release();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd1);
      repeat (4) @(negedge clk);
      arm(0, 24'h800001); arm(1, 24'h7FFFFE);
      wait_done(got, e, b, d2);
      chk(m_total - st == 25, "R7 release edge count", m_total - st, 25);
      chk(lane(0) == sext(24'h800001) && lane(1) == sext(24'h7FFFFE), "R7 release data",
          {lane(0)[31:0], lane(1)[31:0]}, {sext(24'h800001)[31:0], sext(24'h7FFFFE)[31:0]});
   endtask

   task automatic test_all_ready();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd0);
      arm(0, 24'h123456);
      repeat (60) @(negedge clk);
      chk(m_total == st && busy, "R3 held until last lane ready", m_total - st, 0);
      arm(1, 24'hFEDCBA);
      wait_done(got, e, b, d2);
      chk(lane(0) == sext(24'h123456) && lane(1) == sext(24'hFEDCBA), "R3 both lanes read",
          {lane(0)[31:0], lane(1)[31:0]}, {sext(24'h123456)[31:0], sext(24'hFEDCBA)[31:0]});
   endtask

   task automatic test_skew();
      bit got; logic e, b, d2; int st;
      skew_limit = CW'(40);
      disarm(); st = m_total;
      issue(3'd0);
      arm(0, 24'h0F0F0F);
      repeat (20) @(negedge clk);
      chk(m_total == st, "R4 waits inside skew window", m_total - st, 0);
      wait_done(got, e, b, d2);
      chk(got && !e && lane(0) == sext(24'h0F0F0F), "R4 ready lane data", lane(0), sext(24'h0F0F0F));
      chk(lane(1) == 64'hFFFF_FFFF, "R4 late lane reads ones", lane(1), 64'hFFFF_FFFF);
      skew_limit = CW'(1000);
   endtask

   task automatic test_cal();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd2);
      arm(0, 24'h00ABCD); arm(1, 24'hC00000);
      for (int i = 0; i < 5000 && (m_total - st) < 26; i++) @(negedge clk);
      repeat (100) @(negedge clk);
      chk(busy && !done, "R8 busy while calibrating", {busy, done}, 2);
      arm(0, 24'h111111); arm(1, 24'h222222);
      wait_done(got, e, b, d2);
      chk(got && !e && m_total - st == 26, "R8 calibrate edge count", m_total - st, 26);
      chk(lane(0) == sext(24'h00ABCD) && lane(1) == sext(24'hC00000), "R8 calibrate frame data",
          {lane(0)[31:0], lane(1)[31:0]}, {sext(24'h00ABCD)[31:0], sext(24'hC00000)[31:0]});
   endtask

   task automatic test_ignore();
      bit got; logic e, b, d2; int st; bit seen;
      disarm(); st = m_total; seen = 1'b0;
      issue(3'd6);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (busy || done) seen = 1'b1;
      end
      chk(!seen && m_total == st && !sclk, "R2 illegal code ignored", {seen, sclk}, 0);
      issue(3'd0);
      repeat (5) @(negedge clk);
      issue(3'd3);
      arm(0, 24'h333333); arm(1, 24'h444444);
      wait_done(got, e, b, d2);
      repeat (5) @(negedge clk);
      chk(m_total - st == 24 && !sclk, "R2 command while busy dropped", {m_total - st, sclk}, 48);
   endtask

   task automatic test_timeout();
      bit got; logic e, b, d2; int st; logic [LANES*OW-1:0] prev;
      ready_limit = CW'(60);
      disarm(); st = m_total; prev = words;
      issue(3'd0);
      wait_done(got, e, b, d2);
      chk(got && e, "R11 timeout flags err with done", {got, e}, 3);
      chk(m_total == st && words == prev, "R11 no edges and words kept", m_total - st, 0);
      ready_limit = CW'(5000);
   endtask

   task automatic test_standby();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd3);
      wait_done(got, e, b, d2);
      repeat (50) @(negedge clk);
      chk(got && sclk && m_total - st == 1, "R9 standby parks sclk high", {got, sclk}, 3);
   endtask

   task automatic test_single();
      bit got; logic e, b, d2; int st;
      disarm(); st = m_total;
      issue(3'd4);
      for (int i = 0; i < 100 && sclk; i++) @(negedge clk);
      repeat (50) @(negedge clk);
      chk(!sclk && busy && m_total == st, "R10 wake holds sclk low", {sclk, busy}, 1);
      arm(0, 24'h765432); arm(1, 24'h89ABCD);
      wait_done(got, e, b, d2);
      repeat (5) @(negedge clk);
      chk(got && sclk && m_total - st == 25, "R10 single shot edges and park", m_total - st, 25);
      chk(lane(0) == sext(24'h765432) && lane(1) == sext(24'h89ABCD), "R10 single shot data",
          {lane(0)[31:0], lane(1)[31:0]}, {sext(24'h765432)[31:0], sext(24'h89ABCD)[31:0]});
   endtask

   initial begin
      skew_limit  = CW'(1000);
      ready_limit = CW'(5000);
      for (int l = 0; l < LANES; l++) begin
         m_armed[l] = 1'b0;
         m_word[l]  = '0;
         m_base[l]  = 0;
      end
      test_reset();
      test_read();
      test_release();
      test_all_ready();
      test_skew();
      test_cal();
      test_ignore();
      test_timeout();
      test_standby();
      test_single();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
   end
endmodule